// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz reference enable into a strobe that software can use as a periodic interrupt. A free-running binary divider advances once per reference tick. A 4-bit rate code in a byte-wide frequency-select register picks which power-of-two rate reaches the output. The output is a one-cycle `periodic_o` pulse once per selected period.

The register also holds a 3-bit reference-source selector and a spare bit. These are stored and read back only; the divider always assumes the 32.768 kHz time base. Rate code 0 turns the strobe off. Code n (1 to 15) gives 2^(16-n) Hz, so code 1 yields 32768 Hz and code 15 yields 2 Hz. After reset the code is 6, which gives 1024 Hz. A rate write never clears the divider. The new rate therefore starts at the next matching divider transition, and no short or extra pulse is produced.

Top module: `pirq_rate_gen`

## Requirements
- R1: After a synchronous reset, `cfg_rdata_o` reads 0x26 and `periodic_o` is low. In that value, bits [3:0] hold rate code 6, bits [6:4] hold reference-select value 3'b010, and bit 7 is 0.
- R2: While the rate code (bits [3:0] of the register) is 0, `periodic_o` never asserts, whatever `ref_tick_i` does.
- R3: For rate code n in 2..15, count reference ticks from reset, starting at 1. A pulse follows tick t exactly when t mod 2^(n-1) equals 2^(n-2). That is one pulse every 2^(n-1) ticks, or 2^(16-n) Hz.
- R4: With rate code 1, every reference tick produces a pulse (32768 Hz).
- R5: A pulse lasts one clock cycle. It appears in the cycle after the edge that sampled its tick. `periodic_o` is never high unless `ref_tick_i` was high in the cycle before.
- R6: The divider advances only on cycles where `ref_tick_i` is high. Idle cycles between ticks leave the pulse phase unchanged.
- R7: A write with `cfg_we_i` high stores all 8 bits of `cfg_wdata_i`. `cfg_rdata_o` shows them from the next cycle on.
- R8: A rate write does not reset the divider. After a change to code m, the first pulse falls on the next tick t that meets the R3 rule (or the R4 rule) for m.
- R9: With no write after reset, the default code 6 gives its first pulse after tick 16 and then one every 32 ticks (1024 Hz).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick_i | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| cfg_we_i | input | 1 | Write strobe for the frequency-select register |
| cfg_wdata_i | input | 8 | Write data: [3:0] rate code, [6:4] reference select, [7] spare |
| cfg_rdata_o | output | 8 | Current frequency-select register contents |
| periodic_o | output | 1 | One-cycle periodic event strobe |

## Verification
The assertions check the following on every cycle. The divider holds when there is no tick and steps by one on a tick. At most one divider bit rises per tick. Every strobe follows a tick. A zero rate code keeps the strobe low. A write is visible on the readback in the next cycle.

Other behaviour shows only in the bench's directed scenarios, which count ticks from reset. These cover the exact tick on which each rate code fires and the period of every code from 1 to 15. They also cover the 1024 Hz default phase and where the first pulse lands after a rate change.

// File: rtl/pirq_rate_pkg.sv
package pirq_rate_pkg;
    localparam int RATE_W   = 4;
    localparam int SEL_W    = 3;
    localparam int REG_W    = 1 + SEL_W + RATE_W;
    localparam int NUM_TAPS = (1 << RATE_W) - 1;
    localparam int DIV_W    = NUM_TAPS - 1;

    localparam logic [RATE_W-1:0] RATE_DEFAULT = RATE_W'(6);
    localparam logic [SEL_W-1:0]  REF_SEL_32K  = SEL_W'(2);
    localparam logic [RATE_W-1:0] RATE_OFF     = '0;

    typedef struct packed {
        logic              spare;
        logic [SEL_W-1:0]  ref_sel;
        logic [RATE_W-1:0] rate;
    } freq_sel_t;

    localparam freq_sel_t FREQ_SEL_RESET = '{spare: 1'b0, ref_sel: REF_SEL_32K, rate: RATE_DEFAULT};

    function automatic logic rate_enabled(input logic [RATE_W-1:0] code);
        return code != RATE_OFF;
    endfunction
endpackage

// File: rtl/pirq_freq_reg.sv
module pirq_freq_reg
    import pirq_rate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output freq_sel_t        cfg
);
    freq_sel_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= FREQ_SEL_RESET;
        end else if (we) begin
            cfg_q <= freq_sel_t'(wdata);
        end
    end

    assign cfg = cfg_q;

    p_readback_r7: assert property (@(posedge clk) disable iff (rst)
        we |=> (cfg_q == freq_sel_t'($past(wdata))));
endmodule

// File: rtl/pirq_divider.sv
module pirq_divider
    import pirq_rate_pkg::*;
#(
    parameter int WIDTH = DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_nxt;

    assign cnt_nxt = cnt_q + WIDTH'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_nxt;
        end
    end

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_edge
            assign rise[b] = tick & cnt_nxt[b] & ~cnt_q[b];
        end
    endgenerate

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));
    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == WIDTH'($past(cnt_q) + WIDTH'(1))));
    p_one_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rise));
endmodule

// File: rtl/pirq_tap_select.sv
module pirq_tap_select
    import pirq_rate_pkg::*;
(
    input  logic              tick,
    input  logic [DIV_W-1:0]  rise,
    input  logic [RATE_W-1:0] rate,
    output logic              event_o
);
    logic [NUM_TAPS-1:0] taps;

    assign taps = {rise, tick};

    always_comb begin
        event_o = 1'b0;
        for (int i = 1; i <= NUM_TAPS; i++) begin
            if (rate == RATE_W'(i)) begin
                event_o = taps[i-1];
            end
        end
    end
endmodule

// File: rtl/pirq_rate_gen.sv
module pirq_rate_gen
    import pirq_rate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick_i,
    input  logic             cfg_we_i,
    input  logic [REG_W-1:0] cfg_wdata_i,
    output logic [REG_W-1:0] cfg_rdata_o,
    output logic             periodic_o
);
    freq_sel_t        cfg;
    logic [DIV_W-1:0] rise;
    logic             tap_event;
    logic             pulse_q;

    pirq_freq_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we_i),
        .wdata (cfg_wdata_i),
        .cfg   (cfg)
    );

    pirq_divider #(.WIDTH(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (ref_tick_i),
        .rise (rise)
    );

    pirq_tap_select u_sel (
        .tick    (ref_tick_i),
        .rise    (rise),
        .rate    (cfg.rate),
        .event_o (tap_event)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= tap_event;
        end
    end

    assign periodic_o  = pulse_q;
    assign cfg_rdata_o = cfg;

    p_needs_tick_r5: assert property (@(posedge clk) disable iff (rst)
        periodic_o |-> $past(ref_tick_i));
    p_off_silent_r2: assert property (@(posedge clk) disable iff (rst)
        !rate_enabled(cfg.rate) |=> !periodic_o);
endmodule

// File: tb/tb_pirq_rate_gen.sv
module tb_pirq_rate_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst;
    logic       ref_tick_i;
    logic       cfg_we_i;
    logic [7:0] cfg_wdata_i;
    logic [7:0] cfg_rdata_o;
    logic       periodic_o;

    int checks = 0;
    int errors = 0;
    int tcount = 0;
    int cur_code = 6;
    int mism;
    int pulses;
    int first_hit;
    bit done = 0;

    pirq_rate_gen dut (
        .clk         (clk),
        .rst         (rst),
        .ref_tick_i  (ref_tick_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_wdata_i (cfg_wdata_i),
        .cfg_rdata_o (cfg_rdata_o),
        .periodic_o  (periodic_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit hit(input int t, input int code);
        if (code == 0) return 1'b0;
        if (code == 1) return 1'b1;
        return (t % (1 << (code - 1))) == (1 << (code - 2));
    endfunction

    // one cycle: optional tick, compare strobe after the edge
    task automatic step(input bit tick);
        bit exp;
        ref_tick_i = tick;
        @(negedge clk);
        ref_tick_i = 1'b0;
        if (tick) tcount++;
        exp = tick && hit(tcount, cur_code);
        if (periodic_o !== exp) mism++;
        if (periodic_o === 1'b1) begin
            pulses++;
            if (first_hit < 0) first_hit = tcount;
        end
    endtask

    task automatic run(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            step(1'b1);
            for (int g = 0; g < gap; g++) step(1'b0);
        end
    endtask

    task automatic clear_stats();
        mism = 0; pulses = 0; first_hit = -1;
    endtask

    task automatic write_reg(input logic [7:0] v);
        cfg_we_i = 1'b1;
        cfg_wdata_i = v;
        @(negedge clk);
        cfg_we_i = 1'b0;
        cur_code = int'(v[3:0]);
    endtask

    task automatic do_reset();
        rst = 1'b1; ref_tick_i = 1'b0; cfg_we_i = 1'b0; cfg_wdata_i = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tcount = 0; cur_code = 6;
    endtask

    task automatic t_reset();
        do_reset();
        check(cfg_rdata_o === 8'h26, "R1 reset readback", int'(cfg_rdata_o), 'h26);
        check(periodic_o === 1'b0, "R1 reset strobe low", int'(periodic_o), 0);
    endtask

    task automatic t_default();
        do_reset();
        clear_stats();
        run(64, 1);
        check(mism == 0, "R6 phase held over idle cycles", mism, 0);
        check(first_hit == 16, "R9 first default pulse tick", first_hit, 16);
        check(pulses == 2, "R9 default pulse count in 64 ticks", pulses, 2);
    endtask

    task automatic t_disable();
        do_reset();
        write_reg(8'h20);
        clear_stats();
        run(80, 0);
        check(pulses == 0, "R2 code 0 silent", pulses, 0);
        check(mism == 0, "R2 code 0 per-cycle", mism, 0);
    endtask

    task automatic t_code1();
        do_reset();
        write_reg(8'h21);
        clear_stats();
        run(40, 0);
        run(10, 2);
        check(pulses == 50, "R4 code 1 pulse every tick", pulses, 50);
        check(mism == 0, "R4 code 1 per-cycle", mism, 0);
    endtask

    task automatic t_sweep();
        for (int n = 2; n <= 15; n++) begin
            do_reset();
            write_reg(8'(32 + n));
            clear_stats();
            run(2 * (1 << (n - 1)), 0);
            check(pulses == 2, $sformatf("R3 code %0d pulse count", n), pulses, 2);
            check(mism == 0, $sformatf("R3 R5 code %0d per-cycle", n), mism, 0);
            check(first_hit == (1 << (n - 2)), $sformatf("R3 code %0d first tick", n),
                  first_hit, 1 << (n - 2));
        end
    endtask

    task automatic t_readback();
        do_reset();
        write_reg(8'hA5);
        check(cfg_rdata_o === 8'hA5, "R7 readback A5", int'(cfg_rdata_o), 'hA5);
        write_reg(8'h5A);
        check(cfg_rdata_o === 8'h5A, "R7 readback 5A", int'(cfg_rdata_o), 'h5A);
        write_reg(8'hFF);
        check(cfg_rdata_o === 8'hFF, "R7 readback FF", int'(cfg_rdata_o), 'hFF);
    endtask

    task automatic t_change();
        do_reset();
        clear_stats();
        run(10, 0);
        check(pulses == 0, "R8 no pulse before change", pulses, 0);
        write_reg(8'h23);
        clear_stats();
        run(10, 0);
        check(first_hit == 14, "R8 first pulse after change to code 3", first_hit, 14);
        check(mism == 0, "R8 code 3 per-cycle", mism, 0);
        write_reg(8'h26);
        clear_stats();
        run(30, 1);
        check(first_hit == 48, "R8 first pulse after return to code 6", first_hit, 48);
        check(mism == 0, "R8 code 6 per-cycle", mism, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        rst = 1'b1; ref_tick_i = 1'b0; cfg_we_i = 1'b0; cfg_wdata_i = 8'h00;
        @(negedge clk);
        t_reset();
        t_default();
        t_disable();
        t_code1();
        t_readback();
        t_change();
        t_sweep();
        finish_run();
    end
endmodule